// File: doc/BRIEF.md
# Pre-Error Driven Supply Voltage Controller

This block closes a supply-voltage loop around in-situ timing monitors. Each monitored endpoint provides two captured bits: one from its normal capture flop and one from a shadow flop with a longer effective setup time. When the two differ, the path's slack has fallen under a guard margin. That pre-error is a warning only: the functional result is still correct, so nothing is replayed or recovered.

The controller ORs the per-endpoint pre-errors each cycle and adds them into a saturating counter over a programmable observation window. At the end of each window it steps a digital voltage code. A clean window (subject to an optional hysteresis count) moves the code down by one step. A count above a programmable threshold moves it up by one step. Any other count holds the code. Each code change raises a step request toward the external regulator. Counting then pauses until a fixed settle time has passed and the regulator reports ready. A frequency target for the clock generator is derived from the code. Software can hold the loop off with an enable, or force a fixed code through an override.

Top module: `pe_vscale_ctrl`

## Requirements
- R1: After reset, `vcode` equals VMAX (40 by default), `step_req` is 0 and `freq_target` equals FBASE + FSTEP*VMAX (580 by default).
- R2: An endpoint counts as a pre-error in a cycle only when its `mon_main` and `mon_shadow` bits differ. Equal bits (both 0 or both 1) never count. Any number of differing endpoints in one cycle adds exactly one to the window count.
- R3: A window lasts `win_len` counted cycles (0 acts as 1). When a window ends with a count of 0, `vcode` drops by VSTEP (1) but never below VMIN (8), subject to R6.
- R4: When a window ends with a count greater than `err_thresh`, `vcode` rises by VSTEP but never above VMAX. A count from 1 up to `err_thresh` leaves `vcode` unchanged.
- R5: The window count saturates at 2^CW-1 (15 by default), so a threshold of 15 can never trigger a rise.
- R6: A downward step needs max(`hyst_k`,1) consecutive clean windows. A window with a non-zero count restarts that run.
- R7: On every `vcode` change, `step_req` goes to 1 in the same cycle and `step_dir` shows the direction (1 = up). Window counting is suspended while `step_req` is 1. `step_req` clears at the first clock edge at which SETTLE (4) cycles have elapsed since the change and `reg_ready` is 1. A new window then starts from zero.
- R8: `freq_target` always equals FBASE + FSTEP*`vcode` (FBASE 100, FSTEP 12).
- R9: While `ovr_en` is 1, at every edge `vcode` takes `ovr_code` clamped to [VMIN, VMAX], whatever `enable` is. The window count and the clean-window run are held cleared.
- R10: While `enable` is 0 and `ovr_en` is 0, `vcode` holds and the window count and clean-window run are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Loop run enable |
| ovr_en | input | 1 | Force code from `ovr_code` |
| ovr_code | input | VW (6) | Forced voltage code |
| win_len | input | WLW (8) | Observation window length in cycles |
| err_thresh | input | CW (4) | Count above which the code rises |
| hyst_k | input | HW (3) | Clean windows needed before a drop |
| mon_main | input | N_MON (4) | Normal capture bit per endpoint |
| mon_shadow | input | N_MON (4) | Long-setup shadow capture bit per endpoint |
| reg_ready | input | 1 | Regulator has reached its target |
| vcode | output | VW (6) | Voltage target code |
| step_req | output | 1 | Step in progress toward regulator |
| step_dir | output | 1 | Direction of last step, 1 = up |
| freq_target | output | FW (10) | Frequency target for the clock generator |

## Verification
The bench drives the loop to both clamps and holds it there. A design that wrapped or overshot would leave the range or keep stepping. It runs windows whose count equals the threshold and windows whose all-flag count saturates below a threshold of 15. An off-by-one comparison or a wrapping counter would step up where the code must hold. Hysteresis is checked to the exact cycle, including a dirty window that must restart the clean run. A release of `step_req` without `reg_ready`, or counting during the settle period, shows up as a code change too early. Override clamping in both directions, the precedence of override over enable, and matching-but-high endpoint pairs are covered by directed steps. Long random runs with a cycle model cover the rest.

// File: rtl/pe_vsc_pkg.sv
// Shared types for the pre-error voltage controller.
// Assumes: nothing beyond standard SystemVerilog.
package pe_vsc_pkg;
    // Decision taken at the end of an observation window
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_DOWN = 2'd1,
        ACT_UP   = 2'd2
    } step_act_t;
endpackage

// File: rtl/pe_detect.sv
// Per-endpoint mismatch detection between the normal and shadow captures,
// OR-reduced to one flag per cycle.
// Assumes: both capture bits are already in this clock domain.
module pe_detect #(
    parameter int N_MON = 4
) (
    input  logic [N_MON-1:0] mon_main,
    input  logic [N_MON-1:0] mon_shadow,
    output logic             any_flag
);
    logic [N_MON-1:0] mismatch;

    genvar gi;
    generate
        for (gi = 0; gi < N_MON; gi++) begin : g_ep
            // one compare per monitored endpoint
            assign mismatch[gi] = mon_main[gi] ^ mon_shadow[gi];
        end
    endgenerate

    // any endpoint mismatching counts once this cycle
    assign any_flag = |mismatch;
endmodule

// File: rtl/pe_window.sv
// Observation window: counts cycles up to win_len and accumulates the
// per-cycle flag in a saturating counter. Reports the end of window and
// the total including the last cycle's flag.
// Assumes: run low clears the window; win_len of 0 behaves as 1.
module pe_window #(
    parameter int CW  = 4,
    parameter int WLW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           flag,
    input  logic [WLW-1:0] win_len,
    output logic           win_end,
    output logic [CW-1:0]  win_total
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [WLW-1:0] wcnt;
    logic [CW-1:0]  pcnt;
    logic [WLW:0]   wnext;
    logic           last;

    // position of the next cycle and end-of-window test
    always_comb begin
        wnext = {1'b0, wcnt} + {{WLW{1'b0}}, 1'b1};
        last  = (wnext >= {1'b0, win_len});
    end

    // saturating total including this cycle
    assign win_total = (flag && (pcnt != CMAX)) ? pcnt + 1'b1 : pcnt;
    assign win_end   = run && last;

    // window position and count registers
    always_ff @(posedge clk) begin
        if (!rst_n || !run || last) begin
            wcnt <= '0;
            pcnt <= '0;
        end else begin
            wcnt <= wnext[WLW-1:0];
            pcnt <= win_total;
        end
    end
endmodule

// File: rtl/pe_stepper.sv
// Voltage code stepper: window decision with hysteresis and clamps,
// software override, and the settle/ready handshake that blanks counting.
// Assumes: win_end only pulses while not busy, enabled and not overridden.
module pe_stepper
    import pe_vsc_pkg::*;
#(
    parameter int VW     = 6,
    parameter int CW     = 4,
    parameter int HW     = 3,
    parameter int SETTLE = 4,
    parameter int VMIN   = 8,
    parameter int VMAX   = 40,
    parameter int VSTEP  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          ovr_en,
    input  logic [VW-1:0] ovr_code,
    input  logic          win_end,
    input  logic [CW-1:0] win_total,
    input  logic [CW-1:0] err_thresh,
    input  logic [HW-1:0] hyst_k,
    input  logic          reg_ready,
    output logic [VW-1:0] vcode,
    output logic          busy,
    output logic          step_dir
);
    localparam int SW = $clog2(SETTLE + 1);
    localparam logic [VW-1:0] LO = VW'(VMIN);
    localparam logic [VW-1:0] HI = VW'(VMAX);
    localparam logic [SW-1:0] SDONE = SW'(SETTLE);

    logic [HW-1:0] clean, clean_nxt;
    logic [SW-1:0] scnt;
    logic [VW-1:0] want, dn_code, up_code, ovr_clamped;
    logic [VW:0]   up_sum;
    logic [HW:0]   kmin, clean_inc;
    step_act_t     act;

    // clamped neighbour codes and override value
    always_comb begin
        up_sum      = {1'b0, vcode} + (VW+1)'(VSTEP);
        up_code     = (up_sum > {1'b0, HI}) ? HI : up_sum[VW-1:0];
        dn_code     = (vcode >= VW'(VMIN + VSTEP)) ? vcode - VW'(VSTEP) : LO;
        ovr_clamped = (ovr_code < LO) ? LO : ((ovr_code > HI) ? HI : ovr_code);
        kmin        = (hyst_k == '0) ? (HW+1)'(1) : {1'b0, hyst_k};
        clean_inc   = {1'b0, clean} + (HW+1)'(1);
    end

    // window decision and hysteresis run
    always_comb begin
        act       = ACT_HOLD;
        clean_nxt = clean;
        if (ovr_en || !enable) begin
            clean_nxt = '0;
        end else if (win_end) begin
            if (win_total == '0) begin
                if (clean_inc >= kmin) begin
                    act       = ACT_DOWN;
                    clean_nxt = '0;
                end else begin
                    clean_nxt = clean_inc[HW-1:0];
                end
            end else begin
                clean_nxt = '0;
                if (win_total > err_thresh) act = ACT_UP;
            end
        end
    end

    // next code from override or decision
    always_comb begin
        if (ovr_en) begin
            want = ovr_clamped;
        end else begin
            case (act)
                ACT_DOWN: want = dn_code;
                ACT_UP:   want = up_code;
                default:  want = vcode;
            endcase
        end
    end

    // code, handshake and settle timer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vcode    <= HI;
            busy     <= 1'b0;
            step_dir <= 1'b0;
            scnt     <= '0;
            clean    <= '0;
        end else begin
            clean <= clean_nxt;
            if (want != vcode) begin
                vcode    <= want;
                step_dir <= (want > vcode);
                busy     <= 1'b1;
                scnt     <= '0;
            end else if (busy) begin
                if (scnt == SDONE && reg_ready) busy <= 1'b0;
                else if (scnt != SDONE)         scnt <= scnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pe_vscale_ctrl.sv
// Top of the pre-error driven voltage controller: detection, window
// counting and stepping, plus the derived frequency target.
// Assumes: regulator raises reg_ready once it has reached vcode.
module pe_vscale_ctrl #(
    parameter int N_MON  = 4,
    parameter int VW     = 6,
    parameter int CW     = 4,
    parameter int WLW    = 8,
    parameter int HW     = 3,
    parameter int FW     = 10,
    parameter int SETTLE = 4,
    parameter int VMIN   = 8,
    parameter int VMAX   = 40,
    parameter int VSTEP  = 1,
    parameter int FBASE  = 100,
    parameter int FSTEP  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ovr_en,
    input  logic [VW-1:0]    ovr_code,
    input  logic [WLW-1:0]   win_len,
    input  logic [CW-1:0]    err_thresh,
    input  logic [HW-1:0]    hyst_k,
    input  logic [N_MON-1:0] mon_main,
    input  logic [N_MON-1:0] mon_shadow,
    input  logic             reg_ready,
    output logic [VW-1:0]    vcode,
    output logic             step_req,
    output logic             step_dir,
    output logic [FW-1:0]    freq_target
);
    logic          any_flag, run, win_end, busy;
    logic [CW-1:0] win_total;

    // counting runs only when enabled, not forced and not settling
    assign run = enable && !ovr_en && !busy;

    pe_detect #(.N_MON(N_MON)) u_det (
        .mon_main  (mon_main),
        .mon_shadow(mon_shadow),
        .any_flag  (any_flag)
    );

    pe_window #(.CW(CW), .WLW(WLW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .flag     (any_flag),
        .win_len  (win_len),
        .win_end  (win_end),
        .win_total(win_total)
    );

    pe_stepper #(
        .VW(VW), .CW(CW), .HW(HW), .SETTLE(SETTLE),
        .VMIN(VMIN), .VMAX(VMAX), .VSTEP(VSTEP)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .ovr_en    (ovr_en),
        .ovr_code  (ovr_code),
        .win_end   (win_end),
        .win_total (win_total),
        .err_thresh(err_thresh),
        .hyst_k    (hyst_k),
        .reg_ready (reg_ready),
        .vcode     (vcode),
        .busy      (busy),
        .step_dir  (step_dir)
    );

    // handshake and frequency target follow the stepper
    assign step_req    = busy;
    assign freq_target = FW'(FBASE) + FW'(vcode) * FW'(FSTEP);
endmodule

// File: rtl/pe_vscale_ctrl_chk.sv
// Property checker for pe_vscale_ctrl, attached by bind.
// Assumes: reset is held for at least one clock edge.
module pe_vscale_ctrl_chk #(
    parameter int VW    = 6,
    parameter int FW    = 10,
    parameter int VMIN  = 8,
    parameter int VMAX  = 40,
    parameter int VSTEP = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ovr_en,
    input logic          reg_ready,
    input logic [VW-1:0] vcode,
    input logic          step_req,
    input logic          step_dir,
    input logic [FW-1:0] freq_target
);
    // code never leaves the clamp range (R3, R4, R9)
    assert_code_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode >= VW'(VMIN)) && (vcode <= VW'(VMAX)));

    // without override the code moves at most one step per edge
    assert_step_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ovr_en) |->
        (((vcode >= $past(vcode)) ? (vcode - $past(vcode)) : ($past(vcode) - vcode))
         <= VW'(VSTEP)));

    // any code change raises the step request
    assert_req_on_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcode) |-> step_req);

    // direction flag matches the change
    assert_dir_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vcode) |-> (step_dir == (vcode > $past(vcode))));

    // no loop-driven change while settling
    assert_hold_while_settling_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !ovr_en) |=> $stable(vcode));

    // request only released with the regulator ready
    assert_release_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(step_req) |-> $past(reg_ready));

    // a higher code yields a higher frequency target
    assert_freq_tracks_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vcode > $past(vcode)) |-> (freq_target > $past(freq_target)));
endmodule

bind pe_vscale_ctrl pe_vscale_ctrl_chk #(
    .VW(VW), .FW(FW), .VMIN(VMIN), .VMAX(VMAX), .VSTEP(VSTEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovr_en     (ovr_en),
    .reg_ready  (reg_ready),
    .vcode      (vcode),
    .step_req   (step_req),
    .step_dir   (step_dir),
    .freq_target(freq_target)
);

// File: tb/pe_vscale_ctrl_test.sv
// Bench for pe_vscale_ctrl: directed corners plus seeded random traffic,
// checked against a cycle model built from the requirements.
module pe_vscale_ctrl_test;
    localparam int CLK_P  = 10;
    localparam int N      = 4;
    localparam int SETTLE = 4;
    localparam int VMIN   = 8;
    localparam int VMAX   = 40;
    localparam int FBASE  = 100;
    localparam int FSTEP  = 12;
    localparam int CSAT   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, ovr_en = 1'b0, reg_ready = 1'b1;
    logic [5:0] ovr_code = '0;
    logic [7:0] win_len = 8'd4;
    logic [3:0] err_thresh = 4'd2;
    logic [2:0] hyst_k = '0;
    logic [N-1:0] mon_main = '0, mon_shadow = '0;
    logic [5:0] vcode;
    logic       step_req, step_dir;
    logic [9:0] freq_target;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    string ph = "R1";

    // model state
    int m_v, m_busy, m_scnt, m_dir, m_wcnt, m_pcnt, m_clean;

    always #(CLK_P/2) clk = ~clk;

    pe_vscale_ctrl uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ovr_en(ovr_en),
        .ovr_code(ovr_code), .win_len(win_len), .err_thresh(err_thresh),
        .hyst_k(hyst_k), .mon_main(mon_main), .mon_shadow(mon_shadow),
        .reg_ready(reg_ready), .vcode(vcode), .step_req(step_req),
        .step_dir(step_dir), .freq_target(freq_target)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int c);
        return (c < VMIN) ? VMIN : ((c > VMAX) ? VMAX : c);
    endfunction

    // one clock edge of the requirement model
    task automatic model_edge();
        int run, flag, last, tot, wend, want, nclean, kmin;
        run  = (enable && !ovr_en && !m_busy) ? 1 : 0;
        flag = (|(mon_main ^ mon_shadow)) ? 1 : 0;
        last = ((m_wcnt + 1) >= int'(win_len)) ? 1 : 0;
        tot  = (flag != 0 && m_pcnt != CSAT) ? m_pcnt + 1 : m_pcnt;
        wend = run & last;
        kmin = (hyst_k == 0) ? 1 : int'(hyst_k);
        want = m_v; nclean = m_clean;
        if (ovr_en) begin
            want = clampv(int'(ovr_code)); nclean = 0;
        end else if (!enable) begin
            nclean = 0;
        end else if (wend != 0) begin
            if (tot == 0) begin
                if (m_clean + 1 >= kmin) begin nclean = 0; want = clampv(m_v - 1); end
                else nclean = m_clean + 1;
            end else begin
                nclean = 0;
                if (tot > int'(err_thresh)) want = clampv(m_v + 1);
            end
        end
        if (run == 0 || last != 0) begin m_wcnt = 0; m_pcnt = 0; end
        else begin m_wcnt++; m_pcnt = tot; end
        if (want != m_v) begin
            m_dir = (want > m_v) ? 1 : 0; m_v = want; m_busy = 1; m_scnt = 0;
        end else if (m_busy != 0) begin
            if (m_scnt == SETTLE && reg_ready) m_busy = 0;
            else if (m_scnt < SETTLE) m_scnt++;
        end
        m_clean = nclean;
    endtask

    // advance one cycle and compare outputs with the model
    task automatic cyc();
        model_edge();
        @(posedge clk); #1;
        check(int'(vcode) == m_v, {ph, " vcode"}, int'(vcode), m_v);
        check(int'(step_req) == m_busy, "R7 step_req", int'(step_req), m_busy);
        if (m_busy != 0) check(int'(step_dir) == m_dir, "R7 step_dir", int'(step_dir), m_dir);
        check(int'(freq_target) == FBASE + FSTEP*m_v, "R8 freq_target",
              int'(freq_target), FBASE + FSTEP*m_v);
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic set_flags(input bit on);
        mon_main = '0; mon_shadow = on ? 4'b0100 : 4'b0000;
    endtask

    // idle with the loop disabled so windows and settling restart
    task automatic quiesce();
        enable = 0; reg_ready = 1; run_n(10); enable = 1;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v0, seed;
        seed = 7;
        void'($urandom(seed));
        m_v = VMAX; m_busy = 0; m_scnt = 0; m_dir = 0; m_wcnt = 0; m_pcnt = 0; m_clean = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check(int'(vcode) == VMAX, "R1 vcode", int'(vcode), VMAX);
        check(step_req == 1'b0, "R1 step_req", int'(step_req), 0);
        check(int'(freq_target) == FBASE + FSTEP*VMAX, "R1 freq", int'(freq_target), 580);

        // R3 clean windows walk down to the lower clamp
        ph = "R3"; enable = 1; hyst_k = 0; win_len = 4; set_flags(0);
        run_n(400);
        check(int'(vcode) == VMIN, "R3 lower clamp", int'(vcode), VMIN);

        // R4 count equal to threshold holds
        ph = "R4"; err_thresh = 4; set_flags(1); quiesce();
        run_n(60);
        check(int'(vcode) == VMIN, "R4 count==thr hold", int'(vcode), VMIN);

        // R5 saturated count cannot exceed 15, but exceeds 14
        ph = "R5"; win_len = 40; err_thresh = 15; quiesce();
        run_n(100);
        check(int'(vcode) == VMIN, "R5 sat vs 15 hold", int'(vcode), VMIN);
        err_thresh = 14; quiesce();
        run_n(60);
        check(int'(vcode) == VMIN + 1, "R5 sat vs 14 rise", int'(vcode), VMIN + 1);

        // R4 count above threshold walks up to upper clamp
        ph = "R4"; win_len = 4; err_thresh = 2; quiesce();
        run_n(500);
        check(int'(vcode) == VMAX, "R4 upper clamp", int'(vcode), VMAX);

        // R6 hysteresis: first drop at the 12th edge
        ph = "R6"; hyst_k = 3; set_flags(0); quiesce();
        v0 = m_v;
        run_n(11);
        check(int'(vcode) == v0, "R6 before 3rd clean window", int'(vcode), v0);
        run_n(1);
        check(int'(vcode) == v0 - 1, "R6 at 3rd clean window", int'(vcode), v0 - 1);
        // R6 dirty window restarts the run
        quiesce(); v0 = m_v;
        run_n(8);
        set_flags(1); run_n(1); set_flags(0); run_n(3);
        run_n(11);
        check(int'(vcode) == v0, "R6 run restarted", int'(vcode), v0);
        run_n(1);
        check(int'(vcode) == v0 - 1, "R6 drop after restart", int'(vcode), v0 - 1);

        // R7 request held until ready
        ph = "R7"; hyst_k = 0; win_len = 2; quiesce(); reg_ready = 0;
        run_n(32);
        check(step_req == 1'b1, "R7 held without ready", int'(step_req), 1);
        reg_ready = 1; run_n(1);
        check(step_req == 1'b0, "R7 released on ready", int'(step_req), 0);

        // R2 equal-high captures are not pre-errors
        ph = "R2"; win_len = 4; mon_main = '1; mon_shadow = '1; quiesce(); v0 = m_v;
        run_n(50);
        check(int'(vcode) < v0, "R2 equal ones clean", int'(vcode), v0 - 1);

        // R9 override with clamping, priority over enable
        ph = "R9"; ovr_en = 1; ovr_code = 60; run_n(1);
        check(int'(vcode) == VMAX, "R9 clamp high", int'(vcode), VMAX);
        ovr_code = 3; enable = 0; run_n(1);
        check(int'(vcode) == VMIN, "R9 clamp low", int'(vcode), VMIN);
        ovr_code = 20; run_n(1);
        check(int'(vcode) == 20, "R9 forced code", int'(vcode), 20);

        // R10 disabled loop holds its code under any monitor input
        ph = "R10"; ovr_en = 0; run_n(6);
        for (int i = 0; i < 40; i++) begin
            mon_main = 4'($urandom); mon_shadow = 4'($urandom); cyc();
        end
        check(int'(vcode) == 20, "R10 disabled hold", int'(vcode), 20);

        // random traffic against the model
        ph = "R3 R4 R6 random"; enable = 1;
        for (int i = 0; i < 3000; i++) begin
            if (i % 200 == 0) begin
                err_thresh = 4'($urandom_range(0, 6));
                win_len    = 8'($urandom_range(0, 10));
                hyst_k     = 3'($urandom_range(0, 3));
            end
            mon_main   = 4'($urandom);
            mon_shadow = mon_main ^ (($urandom_range(0, 15) == 0) ? 4'($urandom) : 4'd0);
            reg_ready  = ($urandom_range(0, 3) != 0);
            ovr_en     = ($urandom_range(0, 199) == 0);
            ovr_code   = 6'($urandom);
            enable     = ($urandom_range(0, 99) != 0);
            cyc();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule